// File: doc/BRIEF.md
# Four-Step Trim Calibration Sequencer

This block runs the automatic trim calibration of a phase-to-voltage measurement front end. A register write sets a start flag. The sequencer then trims four analog settings one after another: the converter output offset, the clock pulse-width (duty), the data rising-edge delay and the data falling-edge delay. For each setting it runs a successive-approximation search on a digital code. The trial code is driven onto the matching trim output. After a programmable settling time, a single comparator bit reports whether that trial overshoots the point where the converter output equals its reference.

When the sequence starts, the duty and both delay trims are reset to mid-scale. Each result stays in a trim register. After the last step, the sequencer clears the start flag and turns on an open-drain "calibrated" monitor pull-down.

A bypass bit sends mid-scale codes to the duty and delay trims in place of the stored results, but only while no sequence is running. The stored results are kept, so clearing the bypass brings them back. A sleep input freezes the sequencer and all trims where they are. A start request made during sleep is held until sleep ends. Reset is power-on: it places every trim at mid-scale.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset all four trim outputs read mid-scale (32 for 6-bit codes), `mon_pull` is 0 (released), `start_flag` is 0 and `cal_busy` is 0.
- R2: A `start_wr` pulse sets `start_flag`. Outside sleep this launches a sequence, with `cal_busy` high. `cal_step` then runs through 0 (offset), 1 (duty), 2 (rising delay) and 3 (falling delay), in that order.
- R3: At launch the duty, rising-delay and falling-delay trims are set to mid-scale. Each one reads 32 until its own step begins.
- R4: Each step is a 6-bit successive-approximation search, starting from the MSB. The trial code is shown on that step's trim output. After the settling count, a tested bit is cleared when `cmp_hi` is 1, which means the trial exceeds the null point. The bit is kept when `cmp_hi` is 0. The stored result is the largest code that does not exceed the null point.
- R5: `mon_pull` is 0 while `cal_busy` is high. When the sequence completes, `mon_pull` goes to 1 and `start_flag` is cleared at the same time.
- R6: While idle with `bypass_en` = 1, the duty, rising-delay and falling-delay outputs read 32 and the offset output keeps its result. Setting `bypass_en` back to 0 brings the stored results back to the outputs.
- R7: If `bypass_en` and `start_wr` are applied in the same cycle, the full sequence still runs and stores its results. The bypass takes effect once the sequence ends.
- R8: While `sleep_en` is 1 during a sequence, `cal_step` and all trim outputs hold. After wake-up the sequence finishes with the same results it would have reached without the sleep.
- R9: A `start_wr` during sleep sets `start_flag` but does not launch. The sequence starts after `sleep_en` returns to 0.
- R10: Sleep while idle leaves every stored trim unchanged across sleep and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| start_wr | input | 1 | One-cycle write that sets the start flag |
| bypass_en | input | 1 | Apply mid-scale instead of duty/delay results when idle |
| sleep_en | input | 1 | Freeze sequencer and trims |
| cmp_hi | input | 1 | Comparator: trial code is above the null point |
| start_flag | output | 1 | Start bit, cleared on completion |
| cal_busy | output | 1 | Sequence in progress |
| cal_step | output | 2 | Active step: 0 offset, 1 duty, 2 rise, 3 fall |
| mon_pull | output | 1 | Open-drain monitor pull-down enable (1 = calibrated) |
| offset_trim | output | W | Applied offset trim code |
| duty_trim | output | W | Applied duty trim code |
| rise_trim | output | W | Applied rising-edge delay trim code |
| fall_trim | output | W | Applied falling-edge delay trim code |

## Verification
The hardest case to reach is sleep arriving in the middle of a search step. The results must still come out exactly as if no freeze had happened. To reach it, the bench's comparator model runs from the trim outputs, and the bench waits until `cal_step` reads 1 and some settling cycles have passed before raising sleep. It then checks that the step and all trims hold and that the final codes still match the targets. A second hard case is a start written during sleep. For this the bench confirms that the flag is pending and `cal_busy` stays low for many cycles before wake-up.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  localparam int NSTEP = 4;
  typedef enum logic [1:0] {
    STEP_OFS  = 2'd0,
    STEP_DUTY = 2'd1,
    STEP_RISE = 2'd2,
    STEP_FALL = 2'd3
  } step_e;
endpackage

// File: rtl/sar_search.sv
module sar_search #(
  parameter int W      = 6,
  parameter int SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         freeze,
  input  logic         cmp_hi,
  output logic [W-1:0] code,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] cnt;
  logic [BW-1:0] bitpos;
  logic [W-1:0]  nxt;
  logic          sample;

  assign sample = busy && !freeze && (cnt == CW'(SETTLE - 1));

  always_comb begin
    nxt = code;
    if (cmp_hi) nxt[bitpos] = 1'b0;
    if (bitpos != '0) nxt[bitpos - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= MID;
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      bitpos <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        code   <= MID;
        bitpos <= BW'(W - 1);
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy && !freeze) begin
        if (sample) begin
          cnt  <= '0;
          code <= nxt;
          if (bitpos == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitpos <= bitpos - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  initial a_r4_settle_min : assert (SETTLE >= 3);

  // R4: the trial code only moves at a sample instant
  a_r4_code_steady : assert property (@(posedge clk) disable iff (rst)
    (busy && !freeze && !sample && !go) |=> $stable(code));
  // R8: a frozen search keeps both code and settling progress
  a_r8_frozen : assert property (@(posedge clk) disable iff (rst)
    (busy && freeze && !go) |=> ($stable(code) && $stable(cnt)));
endmodule

// File: rtl/trim_bank.sv
module trim_bank #(
  parameter int W = 6,
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                preset,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_data,
  input  logic                busy,
  input  logic                bypass,
  output logic [N-1:0][W-1:0] app
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] trim_q [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        trim_q[i] <= MID;
        app[i]    <= MID;
      end else begin
        if (wr_en && (wr_idx == IW'(i))) trim_q[i] <= wr_data;
        else if (preset && (i != 0))     trim_q[i] <= MID;
        app[i] <= (bypass && !busy && (i != 0)) ? MID : trim_q[i];
      end
    end
  end

  // R3: a launch leaves duty and both delays at mid-scale
  a_r3_preset_mid : assert property (@(posedge clk) disable iff (rst)
    (preset && !wr_en) |=> (trim_q[1] == MID && trim_q[N-1] == MID));
  // R10: with no write or preset, stored trims do not drift
  a_r10_hold : assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !preset) |=> $stable(trim_q[0]));
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq #(
  parameter int W      = 6,
  parameter int SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_wr,
  input  logic         bypass_en,
  input  logic         sleep_en,
  input  logic         cmp_hi,
  output logic         start_flag,
  output logic         cal_busy,
  output logic [1:0]   cal_step,
  output logic         mon_pull,
  output logic [W-1:0] offset_trim,
  output logic [W-1:0] duty_trim,
  output logic [W-1:0] rise_trim,
  output logic [W-1:0] fall_trim
);
  import trim_cal_pkg::*;

  logic  run_q, start_q, mon_q;
  step_e step_q;
  logic  launch, advance, finish, sar_go;
  logic  sar_busy, sar_done;
  logic [W-1:0] sar_code;
  logic [NSTEP-1:0][W-1:0] app;

  assign launch  = !run_q && start_q && !sleep_en;
  assign advance = run_q && sar_done && (step_q != STEP_FALL);
  assign finish  = run_q && sar_done && (step_q == STEP_FALL);
  assign sar_go  = launch || advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      mon_q   <= 1'b0;
      step_q  <= STEP_OFS;
    end else begin
      if (launch) begin
        run_q  <= 1'b1;
        step_q <= STEP_OFS;
        mon_q  <= 1'b0;
      end
      if (advance) step_q <= step_e'(step_q + 2'd1);
      if (finish) begin
        run_q   <= 1'b0;
        start_q <= 1'b0;
        mon_q   <= 1'b1;
      end
      if (start_wr) start_q <= 1'b1;
    end
  end

  sar_search #(.W(W), .SETTLE(SETTLE)) u_sar (
    .clk(clk), .rst(rst), .go(sar_go), .freeze(sleep_en), .cmp_hi(cmp_hi),
    .code(sar_code), .busy(sar_busy), .done(sar_done)
  );

  trim_bank #(.W(W), .N(NSTEP)) u_bank (
    .clk(clk), .rst(rst), .preset(launch),
    .wr_en((sar_busy || sar_done) && run_q), .wr_idx(step_q),
    .wr_data(sar_code), .busy(run_q), .bypass(bypass_en), .app(app)
  );

  assign start_flag  = start_q;
  assign cal_busy    = run_q;
  assign cal_step    = step_q;
  assign mon_pull    = mon_q;
  assign offset_trim = app[STEP_OFS];
  assign duty_trim   = app[STEP_DUTY];
  assign rise_trim   = app[STEP_RISE];
  assign fall_trim   = app[STEP_FALL];

  // R5: monitor stays released for the whole run
  a_r5_mon_released : assert property (@(posedge clk) disable iff (rst)
    run_q |-> !mon_q);
  // R5: monitor turn-on and start-flag clear coincide
  a_r5_start_cleared : assert property (@(posedge clk) disable iff (rst)
    ($rose(mon_q) && !$past(start_wr)) |-> !start_q);
  // R2: steps only ever move forward by one
  a_r2_step_order : assert property (@(posedge clk) disable iff (rst)
    advance |=> (step_q == step_e'($past(step_q) + 2'd1)));
  // R9: no launch while asleep
  a_r9_no_launch_asleep : assert property (@(posedge clk) disable iff (rst)
    (sleep_en && !run_q) |=> !run_q);
endmodule

// File: tb/trim_cal_seq_tb_top.sv
module trim_cal_seq_tb_top;
  localparam int W = 6;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst, start_wr, bypass_en, sleep_en, cmp_hi;
  logic start_flag, cal_busy, mon_pull;
  logic [1:0] cal_step;
  logic [W-1:0] offset_trim, duty_trim, rise_trim, fall_trim;

  int n_chk = 0;
  int n_fail = 0;
  int tgt [4];
  logic [W-1:0] cur;

  always #4 clk = ~clk;

  trim_cal_seq #(.W(W), .SETTLE(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .start_wr(start_wr), .bypass_en(bypass_en),
    .sleep_en(sleep_en), .cmp_hi(cmp_hi), .start_flag(start_flag),
    .cal_busy(cal_busy), .cal_step(cal_step), .mon_pull(mon_pull),
    .offset_trim(offset_trim), .duty_trim(duty_trim),
    .rise_trim(rise_trim), .fall_trim(fall_trim)
  );

  always_comb begin
    case (cal_step)
      2'd0:    cur = offset_trim;
      2'd1:    cur = duty_trim;
      2'd2:    cur = rise_trim;
      default: cur = fall_trim;
    endcase
  end
  assign cmp_hi = cal_busy && (int'(cur) > tgt[cal_step]);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_wr = 1'b1; tick(1); start_wr = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!cal_busy && t < 3000) begin tick(1); t++; end
    while (cal_busy && t < 3000) begin tick(1); t++; end
    check(t < 3000, "R2 completion", t, 0);
    tick(3);
  endtask

  task automatic check_results(input string req);
    check(offset_trim == W'(tgt[0]), req, offset_trim, tgt[0]);
    check(duty_trim   == W'(tgt[1]), req, duty_trim,   tgt[1]);
    check(rise_trim   == W'(tgt[2]), req, rise_trim,   tgt[2]);
    check(fall_trim   == W'(tgt[3]), req, fall_trim,   tgt[3]);
  endtask

  task automatic t_reset();
    check(offset_trim == 32 && duty_trim == 32 && rise_trim == 32 && fall_trim == 32,
          "R1 trims mid", duty_trim, 32);
    check(!mon_pull, "R1 monitor", mon_pull, 0);
    check(!start_flag && !cal_busy, "R1 flags", start_flag, 0);
  endtask

  task automatic t_full_run();
    int seq [4];
    int n = 0;
    int last = -1;
    bit mon_bad = 0;
    tgt = '{13, 50, 0, 63};
    pulse_start();
    check(start_flag, "R2 flag set", start_flag, 1);
    while (!cal_busy) tick(1);
    while (cal_busy) begin
      if (int'(cal_step) != last) begin
        if (n < 4) seq[n] = cal_step;
        n++;
        last = cal_step;
      end
      if (mon_pull) mon_bad = 1;
      tick(1);
    end
    check(n == 4 && seq[0] == 0 && seq[1] == 1 && seq[2] == 2 && seq[3] == 3,
          "R2 step order", n, 4);
    check(!mon_bad, "R5 released while busy", mon_bad, 0);
    check(mon_pull && !start_flag, "R5 done and flag cleared", mon_pull, 1);
    tick(3);
    check_results("R4 search result");
  endtask

  task automatic t_preset();
    tgt = '{40, 7, 22, 45};
    pulse_start();
    while (!(cal_busy && cal_step == 2'd0)) tick(1);
    tick(SETTLE * 2);
    check(duty_trim == 32 && rise_trim == 32 && fall_trim == 32,
          "R3 preset in offset step", duty_trim, 32);
    while (cal_step != 2'd1) tick(1);
    tick(SETTLE * 2);
    check(rise_trim == 32 && fall_trim == 32, "R3 preset in duty step", rise_trim, 32);
    wait_done();
    check_results("R4 second targets");
  endtask

  task automatic t_bypass();
    bypass_en = 1'b1; tick(2);
    check(duty_trim == 32 && rise_trim == 32 && fall_trim == 32,
          "R6 bypass mid", duty_trim, 32);
    check(offset_trim == W'(tgt[0]), "R6 offset kept", offset_trim, tgt[0]);
    bypass_en = 1'b0; tick(2);
    check_results("R6 restore");
  endtask

  task automatic t_bypass_with_start();
    tgt = '{1, 62, 33, 31};
    bypass_en = 1'b1;
    pulse_start();
    wait_done();
    check(mon_pull && !start_flag, "R7 sequence completed", mon_pull, 1);
    check(duty_trim == 32 && fall_trim == 32, "R7 bypass after run", duty_trim, 32);
    check(offset_trim == 1, "R7 offset result", offset_trim, 1);
    bypass_en = 1'b0; tick(2);
    check_results("R7 stored results");
  endtask

  task automatic t_sleep_mid();
    logic [W-1:0] d0, o0;
    logic [1:0] s0;
    tgt = '{20, 9, 44, 3};
    pulse_start();
    while (!(cal_busy && cal_step == 2'd1)) tick(1);
    tick(SETTLE * 3 + 1);
    sleep_en = 1'b1; tick(2);
    d0 = duty_trim; o0 = offset_trim; s0 = cal_step;
    tick(40);
    check(cal_step == s0 && cal_busy, "R8 step frozen", cal_step, s0);
    check(duty_trim == d0 && offset_trim == o0, "R8 trims frozen", duty_trim, d0);
    sleep_en = 1'b0;
    wait_done();
    check_results("R8 result after wake");
  endtask

  task automatic t_sleep_start();
    tgt = '{60, 2, 17, 38};
    sleep_en = 1'b1; tick(1);
    pulse_start();
    tick(50);
    check(start_flag && !cal_busy, "R9 start held", cal_busy, 0);
    sleep_en = 1'b0;
    wait_done();
    check(!start_flag, "R9 flag cleared", start_flag, 0);
    check_results("R9 result");
  endtask

  task automatic t_sleep_idle();
    sleep_en = 1'b1; tick(30);
    sleep_en = 1'b0; tick(3);
    check_results("R10 retained");
  endtask

  initial begin
    rst = 1'b1; start_wr = 1'b0; bypass_en = 1'b0; sleep_en = 1'b0;
    tgt = '{0, 0, 0, 0};
    tick(3);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_full_run();
    t_preset();
    t_bypass();
    t_bypass_with_start();
    t_sleep_mid();
    t_sleep_start();
    t_sleep_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule